// File: doc/BRIEF.md
# Occupancy-Steered Sample Re-timer

This block sits between a recovered audio sample stream, whose timing wobbles, and a converter running from a steady local oscillator. Samples enter a small dual-clock buffer on the write clock and leave it on the read clock, so short-term variation in arrival times never shows up in the output timing. The buffer absorbs the jitter. The local oscillator only has to follow the slow average difference between the two rates.

A controller in the read domain looks at the buffer occupancy once per fixed evaluation interval. It then nudges a digital trim word, which drives an oscillator-control DAC, by one fixed step. The step goes up when the buffer is filling, down when it is draining, and nowhere when the occupancy sits between two watermarks. There is no phase comparison, so the trim follows only long-term drift.

A narrow mode uses a coarse interval and a larger step. A wide mode, meant for varispeed sources, uses a short interval and a small step, so it follows faster at the cost of more clock movement. Buffer misuse is handled without stalling: a write into a full buffer is dropped, and a read from an empty buffer repeats the previous sample. Each case raises a sticky flag.

Top module: `slow_trim_dejitter`

## Requirements
- R1: After reset, `trim` equals the midscale value 2^(TRIM_W-1) (512 by default), `fill` is 0, and both `overflow` and `underflow` are 0.
- R2: Samples leave in the order they were accepted. A `rd_req` seen at a read-clock edge while the buffer holds data presents the oldest sample on `rd_data` after that edge.
- R3: Within four read-clock cycles of the last write or read, `fill` equals the number of accepted samples minus the number read (0 to DEPTH, DEPTH = 64 by default).
- R4: A write while DEPTH samples are held is discarded and leaves the stored samples untouched. The write-side `overflow` flag is set and stays set until reset.
- R5: A `rd_req` while the buffer is empty leaves `rd_data` at its previous value. The read-side `underflow` flag is set and stays set until reset.
- R6: At an evaluation point, occupancy above the high watermark (48 by default) raises `trim` by one step.
- R7: At an evaluation point, occupancy below the low watermark (16 by default) lowers `trim` by one step.
- R8: With occupancy from the low to the high watermark inclusive, `trim` does not change.
- R9: With `wide_en` = 0, the step is 8 and evaluations happen exactly every 512 read-clock cycles.
- R10: With `wide_en` = 1, the step is 2 and evaluations happen exactly every 32 read-clock cycles. Two `trim` changes are never closer than 32 read-clock cycles, in either mode.
- R11: `trim` saturates at 0 and at 2^TRIM_W-1 (1023 by default) rather than wrapping.
- R12: Buffer pointers cross between the clock domains in Gray code through two-flop synchronisers, so each synchronised pointer changes by at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered input sample clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_valid | input | 1 | Sample present on `wr_data` |
| wr_data | input | DATA_W | Incoming sample |
| overflow | output | 1 | Sticky: a write was dropped because the buffer was full |
| rd_clk | input | 1 | Local oscillator clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_req | input | 1 | Converter takes a sample |
| rd_data | output | DATA_W | Outgoing sample, registered |
| underflow | output | 1 | Sticky: a read found the buffer empty |
| fill | output | ADDR_W+1 | Occupancy as seen from the read domain |
| wide_en | input | 1 | Selects the fast-tracking step and interval |
| trim | output | TRIM_W | Frequency trim word for the oscillator-control DAC |

## Verification
The buffer path is driven with random sample values and random gaps between writes, so loss, duplication or reordering shows up in a scoreboard. Filling beyond capacity and reading when empty then isolate the drop and repeat behaviours. The steering loop is held at three fixed occupancies: empty, above the high mark, and between the marks. Measuring both the sign and size of each trim change, and the exact number of cycles between changes, tells up, down and hold apart and tells the two modes apart. Long runs in wide mode drive the trim into both rails to expose wrap-around.

// File: rtl/jtr_pkg.sv
// Package: shared types for the occupancy-steered re-timer.
// Assumes nothing beyond IEEE 1800-2017.
package jtr_pkg;

    // Decision taken by the trim controller at an evaluation point.
    typedef enum logic [1:0] {
        TRIM_HOLD = 2'd0,
        TRIM_UP   = 2'd1,
        TRIM_DOWN = 2'd2
    } trim_dir_e;

endpackage

// File: rtl/jtr_ptr_sync.sv
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes the source changes at most one bit per source-clock cycle.
module jtr_ptr_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);

    logic [W-1:0] stage1;

    // Move the pointer through two flops into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            dst    <= '0;
        end else begin
            stage1 <= src;
            dst    <= stage1;
        end
    end

endmodule

// File: rtl/jtr_async_fifo.sv
// Dual-clock sample buffer with Gray-coded pointer crossing.
// A write into a full buffer is dropped. A read from an empty buffer keeps
// the last output. Each case sets a sticky flag in its own domain.
// Occupancy is reported in the read domain.
module jtr_async_fifo #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              underflow,
    output logic [ADDR_W:0]   fill
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];

    // Write domain state
    logic [PW-1:0] wbin, wgray, rgray_w, rbin_w;
    logic          full;
    // Read domain state
    logic [PW-1:0] rbin, rgray, wgray_r, wbin_r;
    logic          empty;

    jtr_ptr_sync #(.W(PW)) u_rd2wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .src(rgray), .dst(rgray_w)
    );

    jtr_ptr_sync #(.W(PW)) u_wr2rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .src(wgray), .dst(wgray_r)
    );

    // Write-side view of occupancy decides whether there is room.
    always_comb begin
        rbin_w = from_gray(rgray_w);
        full   = (wbin - rbin_w) == PW'(DEPTH);
    end

    // Advance the write pointer or record a dropped sample.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else if (wr_valid) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
        end
    end

    // Store an accepted sample.
    always_ff @(posedge wr_clk) begin
        if (wr_rst_n && wr_valid && !full) begin
            mem[wbin[ADDR_W-1:0]] <= wr_data;
        end
    end

    // Read-side occupancy from the synchronised write pointer.
    always_comb begin
        wbin_r = from_gray(wgray_r);
        fill   = wbin_r - rbin;
        empty  = (fill == '0);
    end

    // Pop the oldest sample, or hold the output and flag an empty read.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            rd_data   <= '0;
            underflow <= 1'b0;
        end else if (rd_req) begin
            if (empty) begin
                underflow <= 1'b1;
            end else begin
                rd_data <= mem[rbin[ADDR_W-1:0]];
                rbin    <= rbin + 1'b1;
                rgray   <= to_gray(rbin + 1'b1);
            end
        end
    end

    // R12: the synchronised write pointer moves by at most one bit.
    p_gray_rd_step_r12: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(wgray_r ^ $past(wgray_r)) <= 1);

    // R12: the synchronised read pointer moves by at most one bit.
    p_gray_wr_step_r12: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(rgray_w ^ $past(rgray_w)) <= 1);

    // R4: a write into a full buffer does not move the write pointer.
    p_drop_when_full_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_valid && full) |=> $stable(wbin));

    // R4: overflow is sticky.
    p_overflow_sticky_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow);

    // R5: an empty read leaves the output unchanged.
    p_empty_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_req && empty) |=> $stable(rd_data));

    // R5: underflow is sticky.
    p_underflow_sticky_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        underflow |=> underflow);

    // R3: the reported occupancy never exceeds the capacity.
    p_fill_bound_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        fill <= (ADDR_W + 1)'(DEPTH));

endmodule

// File: rtl/jtr_trim_ctrl.sv
// Occupancy-driven trim controller. Once per evaluation interval it compares
// the buffer occupancy with two watermarks and moves the trim word by one
// saturating step. Assumes fill is already in this clock domain.
module jtr_trim_ctrl
    import jtr_pkg::*;
#(
    parameter int FILL_W     = 7,
    parameter int TRIM_W     = 10,
    parameter int HI_MARK    = 48,
    parameter int LO_MARK    = 16,
    parameter int N_STEP     = 8,
    parameter int N_INTERVAL = 512,
    parameter int W_STEP     = 2,
    parameter int W_INTERVAL = 32,
    parameter int TRIM_INIT  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_en,
    input  logic [FILL_W-1:0] fill,
    output logic [TRIM_W-1:0] trim
);

    localparam int MAX_INT  = (N_INTERVAL > W_INTERVAL) ? N_INTERVAL : W_INTERVAL;
    localparam int MIN_INT  = (N_INTERVAL < W_INTERVAL) ? N_INTERVAL : W_INTERVAL;
    localparam int MAX_STEP = (N_STEP > W_STEP) ? N_STEP : W_STEP;
    localparam int CNT_W    = $clog2(MAX_INT) + 1;
    localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

    logic [CNT_W-1:0]  ctr, lim;
    logic [TRIM_W-1:0] step, trim_nxt;
    logic [TRIM_W:0]   up_sum;
    trim_dir_e         dir;

    // Pick the interval and step for the current mode.
    always_comb begin
        lim  = wide_en ? CNT_W'(W_INTERVAL - 1) : CNT_W'(N_INTERVAL - 1);
        step = wide_en ? TRIM_W'(W_STEP) : TRIM_W'(N_STEP);
    end

    // Classify occupancy against the watermarks.
    always_comb begin
        if (fill > FILL_W'(HI_MARK))      dir = TRIM_UP;
        else if (fill < FILL_W'(LO_MARK)) dir = TRIM_DOWN;
        else                              dir = TRIM_HOLD;
    end

    // Saturating next trim value.
    always_comb begin
        up_sum = {1'b0, trim} + {1'b0, step};
        unique case (dir)
            TRIM_UP:   trim_nxt = (up_sum > {1'b0, TRIM_MAX}) ? TRIM_MAX : up_sum[TRIM_W-1:0];
            TRIM_DOWN: trim_nxt = (trim < step) ? '0 : trim - step;
            default:   trim_nxt = trim;
        endcase
    end

    // Count the interval and apply the decision at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr  <= '0;
            trim <= TRIM_W'(TRIM_INIT);
        end else if (ctr >= lim) begin
            ctr  <= '0;
            trim <= trim_nxt;
        end else begin
            ctr <= ctr + 1'b1;
        end
    end

    // Checker state: previous trim and cycles since its last change.
    logic [TRIM_W-1:0] trim_prev;
    logic [CNT_W-1:0]  gap;
    logic              moved;
    assign moved = (trim != trim_prev);

    // Track trim history for the spacing and step checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_prev <= TRIM_W'(TRIM_INIT);
            gap       <= '0;
        end else begin
            trim_prev <= trim;
            if (moved)                        gap <= '0;
            else if (gap != CNT_W'(MAX_INT))  gap <= gap + 1'b1;
        end
    end

    // R10: two trim changes are at least the shorter interval apart.
    p_min_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> (gap >= CNT_W'(MIN_INT - 1)));

    // R9: a single change never exceeds the larger step.
    p_step_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> (((trim > trim_prev) ? (trim - trim_prev) : (trim_prev - trim))
                   <= TRIM_W'(MAX_STEP)));

    // R11: a rail is left only in the direction away from it.
    p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_prev == TRIM_MAX && moved) |-> (trim < trim_prev));

endmodule

// File: rtl/slow_trim_dejitter.sv
// Top level: dual-clock sample buffer plus an occupancy-steered trim loop.
// The trim controller runs on the read (local oscillator) clock.
// Assumes each reset is held for at least three cycles of its own clock.
module slow_trim_dejitter #(
    parameter int DATA_W          = 24,
    parameter int ADDR_W          = 6,
    parameter int TRIM_W          = 10,
    parameter int HI_MARK         = 48,
    parameter int LO_MARK         = 16,
    parameter int NARROW_STEP     = 8,
    parameter int NARROW_INTERVAL = 512,
    parameter int WIDE_STEP       = 2,
    parameter int WIDE_INTERVAL   = 32
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              underflow,
    output logic [ADDR_W:0]   fill,
    input  logic              wide_en,
    output logic [TRIM_W-1:0] trim
);

    localparam int TRIM_INIT = 1 << (TRIM_W - 1);

    jtr_async_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_buf (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .overflow  (overflow),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .underflow (underflow),
        .fill      (fill)
    );

    jtr_trim_ctrl #(
        .FILL_W     (ADDR_W + 1),
        .TRIM_W     (TRIM_W),
        .HI_MARK    (HI_MARK),
        .LO_MARK    (LO_MARK),
        .N_STEP     (NARROW_STEP),
        .N_INTERVAL (NARROW_INTERVAL),
        .W_STEP     (WIDE_STEP),
        .W_INTERVAL (WIDE_INTERVAL),
        .TRIM_INIT  (TRIM_INIT)
    ) u_ctrl (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .wide_en (wide_en),
        .fill    (fill),
        .trim    (trim)
    );

endmodule

// File: tb/test_slow_trim_dejitter.sv
module test_slow_trim_dejitter;

    localparam int DW    = 24;
    localparam int AW    = 6;
    localparam int TW    = 10;
    localparam int DEPTH = 64;
    localparam int TMAX  = 1023;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_valid = 1'b0, rd_req = 1'b0, wide_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          overflow, underflow;
    logic [AW:0]   fill;
    logic [TW-1:0] trim;

    int checks = 0;
    int errors = 0;
    int model[$];
    int last_out = 0;

    always #10 wr_clk = ~wr_clk;   // 50 MHz write clock
    always #14 rd_clk = ~rd_clk;   // unrelated local clock

    slow_trim_dejitter i_slow_trim_dejitter (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .overflow(overflow), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req),
        .rd_data(rd_data), .underflow(underflow), .fill(fill), .wide_en(wide_en),
        .trim(trim)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Single write; the bench model applies the capacity rule.
    task automatic push(input int d);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = DW'(d);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        if (model.size() < DEPTH) model.push_back(d);
    endtask

    // Single read, compared with the expected sample (repeat when empty).
    task automatic pop_check(input string req);
        int exp;
        @(negedge rd_clk);
        rd_req = 1'b1;
        @(negedge rd_clk);
        rd_req = 1'b0;
        if (model.size() > 0) exp = model.pop_front();
        else                  exp = last_out;
        last_out = exp;
        check(int'(rd_data) == exp, req, "rd_data", int'(rd_data), exp);
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    // Wait for the next trim change; report its size and the wait length.
    task automatic wait_change(output int d, output int cyc);
        int prev;
        prev = int'(trim);
        cyc = 0;
        do begin
            @(negedge rd_clk);
            cyc++;
        end while (int'(trim) == prev && cyc < 5000);
        d = int'(trim) - prev;
    endtask

    // Wait until trim reaches a target, bounded.
    task automatic wait_trim(input int target);
        int n;
        n = 0;
        while (int'(trim) != target && n < 40000) begin
            @(negedge rd_clk);
            n++;
        end
    endtask

    function automatic int rnd_sample();
        return int'($urandom_range(0, (1 << DW) - 1));
    endfunction

    initial begin
        int d, c, t0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge rd_clk);
        repeat (5) @(negedge wr_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);

        // R1 reset state
        check(trim == TW'(512), "R1", "trim", int'(trim), 512);
        check(fill == '0, "R1", "fill", int'(fill), 0);
        check(!overflow && !underflow, "R1", "flags", int'({overflow, underflow}), 0);

        // R2/R3 random samples with random gaps
        for (int i = 0; i < 20; i++) begin
            repeat ($urandom_range(0, 3)) @(negedge wr_clk);
            push(rnd_sample());
        end
        settle();
        check(int'(fill) == 20, "R3 R12", "fill after 20 writes", int'(fill), 20);
        for (int i = 0; i < 20; i++) pop_check("R2");
        settle();
        check(int'(fill) == 0, "R3", "fill after drain", int'(fill), 0);

        // R5 empty read repeats last sample
        pop_check("R5");
        check(underflow == 1'b1, "R5", "underflow", int'(underflow), 1);

        // R7/R9 empty buffer steps trim down in narrow mode
        wait_change(d, c);
        wait_change(d, c);
        check(d == -8, "R7", "narrow down step", d, -8);
        check(c == 512, "R9", "narrow interval", c, 512);

        // R6 occupancy above high mark steps up
        for (int i = 0; i < 60; i++) push(rnd_sample());
        settle();
        wait_change(d, c);
        wait_change(d, c);
        check(d == 8, "R6", "narrow up step", d, 8);
        check(c == 512, "R9", "narrow interval up", c, 512);

        // R8 occupancy between marks holds
        for (int i = 0; i < 28; i++) pop_check("R2");
        settle();
        check(int'(fill) == 32, "R3", "fill at 32", int'(fill), 32);
        t0 = int'(trim);
        repeat (3 * 512 + 20) @(negedge rd_clk);
        check(int'(trim) == t0, "R8", "trim held", int'(trim), t0);

        // R4 overflow drops excess writes
        for (int i = 0; i < 40; i++) push(rnd_sample());
        settle();
        check(int'(fill) == DEPTH, "R4", "fill when full", int'(fill), DEPTH);
        check(overflow == 1'b1, "R4", "overflow", int'(overflow), 1);
        for (int i = 0; i < DEPTH; i++) pop_check("R4");
        settle();
        check(overflow == 1'b1, "R4", "overflow sticky", int'(overflow), 1);
        check(underflow == 1'b1, "R5", "underflow sticky", int'(underflow), 1);

        // R10 wide mode step and interval
        @(negedge rd_clk) wide_en = 1'b1;
        wait_change(d, c);
        wait_change(d, c);
        check(d == -2, "R10", "wide down step", d, -2);
        check(c == 32, "R10", "wide interval", c, 32);

        // R11 lower rail
        wait_trim(0);
        check(trim == '0, "R11", "reach zero", int'(trim), 0);
        repeat (100) @(negedge rd_clk);
        check(trim == '0, "R11", "stay zero", int'(trim), 0);

        // R11 upper rail
        for (int i = 0; i < 60; i++) push(rnd_sample());
        settle();
        wait_trim(TMAX);
        check(int'(trim) == TMAX, "R11", "reach max", int'(trim), TMAX);
        repeat (100) @(negedge rd_clk);
        check(int'(trim) == TMAX, "R11", "stay max", int'(trim), TMAX);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule